// File: doc/BRIEF.md
# Storage PHY Control Register Bank

This block is a small register file that holds the settings of a storage-interface PHY and reports its status. Software reaches it over a plain address, write-strobe and read-strobe bus. The bank has seven 16-bit control words at word-aligned offsets 0x00 through 0x18 and one read-only status word at offset 0x20. Every bus word is 32 bits wide.

Writes are masked. The upper half of each written data word is a per-bit enable for the lower half, so any single field can be changed without first reading the word. The tap/frequency word (word 0) and the power/DLL word (word 6) are decoded into named output ports. Words 1 to 5 are driven out as raw 16-bit slices. The status word is a live view of the PHY's status inputs.

Reads are registered. Data and a one-cycle valid strobe appear on the cycle after the read address is presented.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: While reset is high, and after it is released, every control word is zero and `bus_rvalid` is 0. This means `phy_power_up` = 0 and `dll_enable` = 0.
- R2: A write to a control word changes bit n (n = 0..15) only when bit n+16 of `bus_wdata` is 1. All other bits keep their values. A write with a zero mask changes nothing.
- R3: Control word k (k = 0..6) sits at byte offset 4*k. A read of it returns its 16 bits in `bus_rdata[15:0]`, and `bus_rdata[31:16]` reads 0 for every read.
- R4: Word 0 bit layout drives the tap ports: `freq_sel` = bits 13:12, `otap_en` = bit 11, `otap_sel` = bits 10:7, `itap_win` = bit 6, `itap_sel` = bits 5:1, `itap_en` = bit 0. The `freq_sel` codes are 0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz.
- R5: A read at offset 0x20 returns the status inputs as sampled at the read edge. `cal_done` is in bit 6, `dll_ready` in bit 5, `rtrim_val` in bits 4:1 and `ext_res` in bit 0. All other bits are 0.
- R6: Word 6 bit layout drives the power ports: `dll_trim` = bits 12:9, `rtrim_en` = bit 8, `retrim` = bit 7, `drive_type` = bits 6:4, `retention` = bits 3:2, `dll_enable` = bit 1, `phy_power_up` = bit 0 (1 = powered).
- R7: A write to offset 0x20, to a non-word-aligned offset, or to any offset above 0x18 other than 0x20 changes no control word.
- R8: `bus_rvalid` is 1 in exactly the cycle after each cycle with `bus_rd` high, and 0 otherwise. A read of an unmapped offset returns 0.
- R9: When a read and a write hit the same control word in the same cycle, the read returns the value from before the write. The write still takes effect.
- R10: Words 1 to 5 appear on `aux_ctrl`, with word k at bits (k-1)*16 + 15 down to (k-1)*16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] values |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle |
| cal_done | input | 1 | Status: calibration complete |
| dll_ready | input | 1 | Status: DLL locked |
| rtrim_val | input | 4 | Status: resistor trim code |
| ext_res | input | 1 | Status: external resistor present |
| freq_sel | output | 2 | DLL frequency band code |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |
| itap_win | output | 1 | Input tap change window |
| itap_sel | output | 5 | Input tap delay select |
| itap_en | output | 1 | Input tap delay enable |
| dll_trim | output | 4 | DLL charge-pump trim |
| rtrim_en | output | 1 | Resistor retrim enable |
| retrim | output | 1 | Retrim request |
| drive_type | output | 3 | Pad drive type |
| retention | output | 2 | Retention controls |
| dll_enable | output | 1 | DLL enable |
| phy_power_up | output | 1 | PHY power up |
| aux_ctrl | output | 80 | Control words 1 to 5 |

## Verification
A read and a write can land in the same cycle. When both target the same control word, the read must return the old contents while the write still lands. When the read targets the status word, it must capture the status inputs as they stand at that edge, even if they change in the same cycle.

The bench provokes both cases. It issues combined read/write cycles to the same and to different offsets, and it toggles the random status inputs on the same negative edge as the read. It compares the returned word with a model value taken before its own masked update, and then reads the word back to confirm that the write took effect.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = DATA_W / 2;
    localparam int NUM_CTRL   = 7;
    localparam int NUM_AUX    = NUM_CTRL - 2;
    localparam int AUX_W      = NUM_AUX * HALF_W;
    localparam int TAP_IDX    = 0;
    localparam int PWR_IDX    = NUM_CTRL - 1;
    localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(6'h20);

    typedef enum logic [1:0] {
        FRQ_200 = 2'd0,
        FRQ_50  = 2'd1,
        FRQ_100 = 2'd2,
        FRQ_150 = 2'd3
    } freq_band_e;

    typedef struct packed {
        freq_band_e  band;
        logic        otap_en;
        logic [3:0]  otap_sel;
        logic        itap_win;
        logic [4:0]  itap_sel;
        logic        itap_en;
    } tap_cfg_t;

    typedef struct packed {
        logic [3:0]  trim;
        logic        rtrim_en;
        logic        retrim;
        logic [2:0]  drive;
        logic [1:0]  reten;
        logic        dll_en;
        logic        pwr_up;
    } pwr_cfg_t;

    typedef struct packed {
        logic        cal_done;
        logic        dll_rdy;
        logic [3:0]  rtrim;
        logic        ext_res;
    } phy_stat_t;

    localparam int TAP_W  = $bits(tap_cfg_t);
    localparam int PWR_W  = $bits(pwr_cfg_t);
    localparam int STAT_W = $bits(phy_stat_t);

    typedef logic [HALF_W-1:0] ctrl_word_t;

    function automatic ctrl_word_t masked_merge(input ctrl_word_t old,
                                                input logic [DATA_W-1:0] wd);
        ctrl_word_t en;
        en = wd[DATA_W-1:HALF_W];
        return (old & ~en) | (wd[HALF_W-1:0] & en);
    endfunction

    function automatic logic [ADDR_W-1:0] word_offset(input int idx);
        return ADDR_W'(idx * 4);
    endfunction

    function automatic tap_cfg_t to_tap(input ctrl_word_t w);
        return tap_cfg_t'(w[TAP_W-1:0]);
    endfunction

    function automatic pwr_cfg_t to_pwr(input ctrl_word_t w);
        return pwr_cfg_t'(w[PWR_W-1:0]);
    endfunction

endpackage

// File: rtl/phyreg_decode.sv
module phyreg_decode
    import phyreg_pkg::*;
#(
    parameter int N_WORDS = NUM_CTRL
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_WORDS-1:0] ctrl_hit,
    output logic               stat_hit
);

    for (genvar i = 0; i < N_WORDS; i++) begin : g_hit
        assign ctrl_hit[i] = (addr == word_offset(i));
    end

    assign stat_hit = (addr == STATUS_OFS);

endmodule

// File: rtl/phyreg_word.sv
module phyreg_word
    import phyreg_pkg::*;
#(
    parameter ctrl_word_t RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_word_t        q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (we) begin
            q <= masked_merge(q, wdata);
        end
    end

endmodule

// File: rtl/phyreg_rdmux.sv
module phyreg_rdmux
    import phyreg_pkg::*;
#(
    parameter int N_WORDS = NUM_CTRL
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd,
    input  logic [N_WORDS-1:0]          ctrl_hit,
    input  logic                        stat_hit,
    input  ctrl_word_t [N_WORDS-1:0]    words,
    input  phy_stat_t                   stat,
    output logic [DATA_W-1:0]           rdata,
    output logic                        rvalid
);

    logic [DATA_W-1:0] sel_data;

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (ctrl_hit[i]) begin
                sel_data[HALF_W-1:0] = sel_data[HALF_W-1:0] | words[i];
            end
        end
        if (stat_hit) begin
            sel_data[STAT_W-1:0] = sel_data[STAT_W-1:0] | stat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) begin
                rdata <= sel_data;
            end
        end
    end

endmodule

// File: rtl/phy_ctrl_regbank.sv
module phy_ctrl_regbank
    import phyreg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  cal_done,
    input  logic                  dll_ready,
    input  logic [3:0]            rtrim_val,
    input  logic                  ext_res,
    output logic [1:0]            freq_sel,
    output logic                  otap_en,
    output logic [3:0]            otap_sel,
    output logic                  itap_win,
    output logic [4:0]            itap_sel,
    output logic                  itap_en,
    output logic [3:0]            dll_trim,
    output logic                  rtrim_en,
    output logic                  retrim,
    output logic [2:0]            drive_type,
    output logic [1:0]            retention,
    output logic                  dll_enable,
    output logic                  phy_power_up,
    output logic [AUX_W-1:0]      aux_ctrl
);

    logic [NUM_CTRL-1:0]        ctrl_hit;
    logic                       stat_hit;
    ctrl_word_t [NUM_CTRL-1:0]  words;
    phy_stat_t                  stat;
    tap_cfg_t                   tap;
    pwr_cfg_t                   pwr;

    phyreg_decode #(.N_WORDS(NUM_CTRL)) u_dec (
        .addr     (bus_addr),
        .ctrl_hit (ctrl_hit),
        .stat_hit (stat_hit)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_word
        phyreg_word #(.RESET_VAL('0)) u_word (
            .clk   (clk),
            .rst   (rst),
            .we    (bus_wr && ctrl_hit[i]),
            .wdata (bus_wdata),
            .q     (words[i])
        );
    end

    assign stat = '{cal_done: cal_done, dll_rdy: dll_ready,
                    rtrim: rtrim_val, ext_res: ext_res};

    phyreg_rdmux #(.N_WORDS(NUM_CTRL)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd       (bus_rd),
        .ctrl_hit (ctrl_hit),
        .stat_hit (stat_hit),
        .words    (words),
        .stat     (stat),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

    assign tap = to_tap(words[TAP_IDX]);
    assign pwr = to_pwr(words[PWR_IDX]);

    assign freq_sel     = tap.band;
    assign otap_en      = tap.otap_en;
    assign otap_sel     = tap.otap_sel;
    assign itap_win     = tap.itap_win;
    assign itap_sel     = tap.itap_sel;
    assign itap_en      = tap.itap_en;

    assign dll_trim     = pwr.trim;
    assign rtrim_en     = pwr.rtrim_en;
    assign retrim       = pwr.retrim;
    assign drive_type   = pwr.drive;
    assign retention    = pwr.reten;
    assign dll_enable   = pwr.dll_en;
    assign phy_power_up = pwr.pwr_up;

    for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux
        assign aux_ctrl[k*HALF_W +: HALF_W] = words[k+1];
    end

endmodule

// File: rtl/phyreg_checker.sv
module phyreg_checker
    import phyreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic [STAT_W-1:0] stat_in,
    input logic [TAP_W+PWR_W+AUX_W-1:0] ctl_vec
);

    logic addr_unmapped_wr;
    assign addr_unmapped_wr = (bus_addr[1:0] != 2'b00) ||
                              (bus_addr[ADDR_W-1:2] > (NUM_CTRL - 1));

    // R8
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    // R8
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (bus_rdata[DATA_W-1:HALF_W] == '0));

    // R2
    no_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[DATA_W-1:HALF_W] == '0) |=> $stable(ctl_vec));

    // R7
    ignore_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_unmapped_wr) |=> $stable(ctl_vec));

    // R5
    status_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STATUS_OFS) |=>
            (bus_rdata == DATA_W'($past(stat_in))));

endmodule

bind phy_ctrl_regbank phyreg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .stat_in    ({cal_done, dll_ready, rtrim_val, ext_res}),
    .ctl_vec    ({freq_sel, otap_en, otap_sel, itap_win, itap_sel, itap_en,
                  dll_trim, rtrim_en, retrim, drive_type, retention,
                  dll_enable, phy_power_up, aux_ctrl})
);

// File: tb/tb_phy_ctrl_regbank.sv
module tb_phy_ctrl_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        cal_done = 1'b0;
    logic        dll_ready = 1'b0;
    logic [3:0]  rtrim_val = '0;
    logic        ext_res = 1'b0;
    logic [1:0]  freq_sel;
    logic        otap_en;
    logic [3:0]  otap_sel;
    logic        itap_win;
    logic [4:0]  itap_sel;
    logic        itap_en;
    logic [3:0]  dll_trim;
    logic        rtrim_en;
    logic        retrim;
    logic [2:0]  drive_type;
    logic [1:0]  retention;
    logic        dll_enable;
    logic        phy_power_up;
    logic [79:0] aux_ctrl;

    int errors = 0;
    int checks = 0;
    logic [15:0] model [7];

    always #5 clk = ~clk;

    phy_ctrl_regbank dut (.*);

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int word_of(input logic [5:0] a);
        if (a[1:0] == 2'b00 && a[5:2] <= 4'd6) return int'(a[5:2]);
        return -1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        int w;
        w = word_of(a);
        if (w >= 0) return {16'h0, model[w]};
        if (a == 6'h20) return {25'h0, cal_done, dll_ready, rtrim_val, ext_res};
        return 32'h0;
    endfunction

    task automatic check_ports(input string tag);
        check({tag, " R4 tap ports"},
              {freq_sel, otap_en, otap_sel, itap_win, itap_sel, itap_en},
              {model[0][13:12], model[0][11], model[0][10:7], model[0][6],
               model[0][5:1], model[0][0]});
        check({tag, " R6 pwr ports"},
              {dll_trim, rtrim_en, retrim, drive_type, retention, dll_enable, phy_power_up},
              {model[6][12:9], model[6][8], model[6][7], model[6][6:4],
               model[6][3:2], model[6][1], model[6][0]});
        check({tag, " R10 aux ports"}, aux_ctrl,
              {model[5], model[4], model[3], model[2], model[1]});
    endtask

    // one bus cycle; inputs set after a negedge, results checked at the next negedge
    task automatic cyc(input logic w, input logic r, input logic [5:0] a,
                       input logic [31:0] d, input string req);
        logic [31:0] er;
        int wi;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        er = exp_read(a);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        wi = word_of(a);
        if (w && wi >= 0)
            model[wi] = (model[wi] & ~d[31:16]) | (d[15:0] & d[31:16]);
        if (r) begin
            check({req, " R8 rvalid"}, 80'(bus_rvalid), 80'(1));
            check({req, " read"}, 80'(bus_rdata), 80'(er));
        end else begin
            check({req, " R8 rvalid low"}, 80'(bus_rvalid), 80'(0));
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < 7; i++) model[i] = 16'h0;
        repeat (4) @(negedge clk);
        // R1 reset state while reset is held
        check("R1 rvalid in reset", 80'(bus_rvalid), 80'(0));
        check("R1 power/dll off", {78'h0, phy_power_up, dll_enable}, 80'h0);
        rst = 1'b0;
        @(negedge clk);
        check_ports("R1 after reset");
        for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 6'(i * 4), 32'h0, "R1 R3 reset read");

        // R4 directed: band codes and field bits
        cyc(1'b1, 1'b0, 6'h00, 32'hFFFF_2000, "R4 freq 100");
        check("R4 band 100MHz code", 80'(freq_sel), 80'(2));
        cyc(1'b1, 1'b0, 6'h00, 32'h3000_1000, "R4 freq 50");
        check("R4 band 50MHz code", 80'(freq_sel), 80'(1));
        check_ports("R4");
        // R6 directed: power up then DLL enable
        cyc(1'b1, 1'b0, 6'h18, 32'h0001_0001, "R6 pwr up");
        check("R6 power up", {phy_power_up, dll_enable}, 80'b10);
        cyc(1'b1, 1'b0, 6'h18, 32'h0002_FFFF, "R6 dll en");
        check("R6 dll on, pwr kept R2", {phy_power_up, dll_enable}, 80'b11);
        // R2 zero mask, R7 ignored writes
        cyc(1'b1, 1'b0, 6'h18, 32'h0000_0000, "R2 zero mask");
        cyc(1'b1, 1'b0, 6'h20, 32'hFFFF_FFFF, "R7 status wr");
        cyc(1'b1, 1'b0, 6'h01, 32'hFFFF_FFFF, "R7 misaligned wr");
        cyc(1'b1, 1'b0, 6'h1C, 32'hFFFF_FFFF, "R7 gap wr");
        check_ports("R2 R7");
        for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 6'(i * 4), 32'h0, "R7 readback");
        // R5 status layout
        cal_done = 1'b1; dll_ready = 1'b0; rtrim_val = 4'hA; ext_res = 1'b1;
        cyc(1'b0, 1'b1, 6'h20, 32'h0, "R5 status");
        // R9 same-cycle read and write
        cyc(1'b1, 1'b1, 6'h08, 32'hFFFF_BEEF, "R9 rd+wr");
        cyc(1'b0, 1'b1, 6'h08, 32'h0, "R9 post write");
        // R8 unmapped read
        cyc(1'b0, 1'b1, 6'h3C, 32'h0, "R8 unmapped read");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [5:0] a;
            logic w, r;
            logic [31:0] d;
            case ($urandom % 4)
                0, 1:    a = 6'(($urandom % 7) * 4);
                2:       a = 6'h20;
                default: a = 6'($urandom);
            endcase
            w = 1'($urandom);
            r = 1'($urandom);
            d = $urandom;
            cal_done = 1'($urandom); dll_ready = 1'($urandom);
            rtrim_val = 4'($urandom); ext_res = 1'($urandom);
            cyc(w, r, a, d, "R2 R3 R5 R9 random");
            if (n % 16 == 0) check_ports("R2 random");
        end
        check_ports("R2 final");
        for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 6'(i * 4), 32'h0, "R3 final read");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule